// File: doc/BRIEF.md
# SMBus Transaction Timeout Watchdog

This block sits next to an SMBus master's bit engine and watches every transaction for a device that stops responding. When the master has sent its first bit and is waiting on the target (for an acknowledge, or for the clock line to be released), the watchdog counts ticks of a slow real-time clock. If the count reaches the timeout threshold, it sends the bit engine a one-cycle abort request so that the cycle is discarded. It also raises a sticky device-error flag that stays set until software clears it.

The slow clock arrives as a single-cycle enable pulse that is already synchronized to the system clock. The default threshold of 800 ticks of a 32 kHz clock gives a timeout of at least 25 ms. Counting is held while the byte-done status is set, unless the second-timeout status is also set. The block also forwards byte-completion events. A timeout in the same cycle as a byte completion takes precedence over it.

Top module: `smb_timeout_wdog`

## Requirements
- R1: After reset, `dev_err`, `abort_req` and `byte_ok` are 0 and the tick count is 0.
- R2: The count can advance only while `xfer_active`, `first_bit_sent` and `wait_resp` are all 1. In any cycle where one of them is 0, the count returns to 0.
- R3: The count advances by one only in a cycle where `tick` is 1. `abort_req` is 1 in the cycle that follows the LIMIT-th counted tick (LIMIT defaults to 800), and is never 1 earlier.
- R4: A tick is not counted while `byte_done` is 1 and `second_to` is 0. While `second_to` is 1, a tick is counted whatever the value of `byte_done`.
- R5: `abort_req` is a pulse one cycle long. It is issued at most once per waiting interval, because the count holds at LIMIT until the count is cleared.
- R6: `dev_err` goes to 1 in the same cycle as `abort_req` and stays 1 until `clr_err` is 1. If a timeout and `clr_err` fall in the same cycle, `dev_err` stays set.
- R7: A 1 on `resp_evt` (acknowledge received, or clock line seen high) returns the count to 0, so the full LIMIT ticks are needed again.
- R8: `byte_ok` is 1 one cycle after `byte_evt` is 1. It stays 0 if a timeout fires in the same cycle as the byte event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle slow-clock enable pulse |
| xfer_active | input | 1 | A transaction is in progress |
| first_bit_sent | input | 1 | The master has sent its first bit |
| wait_resp | input | 1 | The master is waiting for the target |
| resp_evt | input | 1 | A response was seen this cycle |
| byte_done | input | 1 | Byte-done status level |
| second_to | input | 1 | Second-timeout status level |
| byte_evt | input | 1 | A byte completed this cycle |
| clr_err | input | 1 | Write-one-to-clear strobe for the error flag |
| dev_err | output | 1 | Sticky device-error flag |
| abort_req | output | 1 | One-cycle abort request to the bit engine |
| byte_ok | output | 1 | Byte completion forwarded with timeout priority |

## Verification
If the internal count drifts, the abort pulse appears at the wrong tick. A count that advances while frozen or unarmed, or that fails to clear on a response, shows up as an early or missing `abort_req` within one LIMIT-tick window. That is 800 ticks, and the directed tests shorten it to 800 cycles by pulsing `tick` every cycle. A wrong error-flag state shows on `dev_err` one cycle after the abort, or one cycle after a clear. A wrong priority choice shows on `byte_ok` in the cycle after the colliding events.

// File: rtl/smb_timeout_wdog.sv
module smb_timeout_wdog #(
  parameter int LIMIT = 800,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic xfer_active,
  input  logic first_bit_sent,
  input  logic wait_resp,
  input  logic resp_evt,
  input  logic byte_done,
  input  logic second_to,
  input  logic byte_evt,
  input  logic clr_err,
  output logic dev_err,
  output logic abort_req,
  output logic byte_ok
);
  logic [CW-1:0] cnt;

  wire armed  = xfer_active & first_bit_sent & wait_resp;
  wire frozen = byte_done & ~second_to;
  wire adv    = armed & ~resp_evt & tick & ~frozen & (cnt != CW'(LIMIT));
  wire fire   = adv & (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      dev_err   <= 1'b0;
      abort_req <= 1'b0;
      byte_ok   <= 1'b0;
    end else begin
      if (!armed || resp_evt) cnt <= '0;
      else if (adv)           cnt <= cnt + 1'b1;
      abort_req <= fire;
      byte_ok   <= byte_evt & ~fire;
      if (fire)         dev_err <= 1'b1;
      else if (clr_err) dev_err <= 1'b0;
    end
  end
endmodule

module smb_timeout_wdog_chk #(
  parameter int LIMIT = 800,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic xfer_active,
  input logic first_bit_sent,
  input logic wait_resp,
  input logic resp_evt,
  input logic byte_done,
  input logic second_to,
  input logic clr_err,
  input logic dev_err,
  input logic abort_req,
  input logic byte_ok,
  input logic [CW-1:0] cnt
);
  wire armed = xfer_active & first_bit_sent & wait_resp;

  a_r2_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> cnt == '0);
  a_r3_abort_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !abort_req);
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && byte_done && !second_to && !resp_evt) |=> cnt == $past(cnt));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);
  a_r6_err_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> dev_err);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!dev_err || abort_req));
  a_r7_resp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resp_evt |=> cnt == '0);
  a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !byte_ok);
endmodule

bind smb_timeout_wdog smb_timeout_wdog_chk #(.LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .xfer_active(xfer_active),
  .first_bit_sent(first_bit_sent), .wait_resp(wait_resp), .resp_evt(resp_evt),
  .byte_done(byte_done), .second_to(second_to), .clr_err(clr_err),
  .dev_err(dev_err), .abort_req(abort_req), .byte_ok(byte_ok), .cnt(cnt)
);

// File: tb/smb_timeout_wdog_test.sv
module smb_timeout_wdog_test;
  localparam int LIMIT = 800;

  logic clk = 0, rst_n = 0;
  logic tick = 0, xfer_active = 0, first_bit_sent = 0, wait_resp = 0;
  logic resp_evt = 0, byte_done = 0, second_to = 0, byte_evt = 0, clr_err = 0;
  logic dev_err, abort_req, byte_ok;

  int errors = 0, checks = 0, cycles = 0;
  int m_cnt = 0;
  logic m_err = 0, m_abort = 0, m_byte = 0;

  always #10 clk = ~clk;

  smb_timeout_wdog #(.LIMIT(LIMIT)) uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic fires(int c);
    return xfer_active && first_bit_sent && wait_resp && !resp_evt && tick &&
           !(byte_done && !second_to) && c == LIMIT - 1;
  endfunction

  function automatic int next_cnt(int c);
    if (!(xfer_active && first_bit_sent && wait_resp) || resp_evt) return 0;
    if (tick && !(byte_done && !second_to) && c != LIMIT) return c + 1;
    return c;
  endfunction

  task automatic step();
    logic f;
    f = fires(m_cnt);
    @(posedge clk); #2;
    m_abort = f;
    m_byte = byte_evt && !f;
    if (f) m_err = 1; else if (clr_err) m_err = 0;
    m_cnt = next_cnt(m_cnt);
    check(abort_req === m_abort, "R5 abort_req", abort_req, m_abort);
    check(dev_err === m_err, "R6 dev_err", dev_err, m_err);
    check(byte_ok === m_byte, "R8 byte_ok", byte_ok, m_byte);
    tick = 0; resp_evt = 0; byte_evt = 0; clr_err = 0;
  endtask

  task automatic arm(input logic a);
    xfer_active = a; first_bit_sent = a; wait_resp = a;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    // R1 reset state
    check(dev_err === 0 && abort_req === 0 && byte_ok === 0, "R1 reset outputs",
          {dev_err, abort_req, byte_ok}, 0);

    // R3: exact threshold
    arm(1);
    ticks(LIMIT - 1);
    check(abort_req === 0, "R3 no abort before limit", abort_req, 0);
    ticks(1);
    check(abort_req === 1, "R3 abort at limit", abort_req, 1);
    check(dev_err === 1, "R6 err set with abort", dev_err, 1);
    ticks(5);
    check(abort_req === 0, "R5 saturates, no second abort", abort_req, 0);
    clr_err = 1; step();
    check(dev_err === 0, "R6 cleared by strobe", dev_err, 0);

    // R2: unarmed never counts
    arm(0); first_bit_sent = 1; xfer_active = 1;
    ticks(LIMIT + 10);
    check(abort_req === 0 && dev_err === 0, "R2 waiting low blocks count", dev_err, 0);

    // R7: response near the end restarts the window
    arm(1);
    ticks(LIMIT - 1);
    resp_evt = 1; step();
    ticks(LIMIT - 1);
    check(dev_err === 0, "R7 response restarted count", dev_err, 0);
    ticks(1);
    check(abort_req === 1, "R7 full window after response", abort_req, 1);

    // R4: frozen then override
    arm(0); step(); arm(1);
    ticks(LIMIT - 1);
    byte_done = 1;
    ticks(50);
    check(abort_req === 0, "R4 frozen while byte_done", abort_req, 0);
    second_to = 1;
    ticks(1);
    check(abort_req === 1, "R4 second_to overrides freeze", abort_req, 1);
    byte_done = 0; second_to = 0;

    // R6 + R8: timeout, clear and byte event in the same cycle
    arm(0); step(); arm(1);
    ticks(LIMIT - 1);
    tick = 1; clr_err = 1; byte_evt = 1; step();
    check(dev_err === 1, "R6 set wins over clear", dev_err, 1);
    check(byte_ok === 0, "R8 timeout suppresses byte_ok", byte_ok, 0);
    byte_evt = 1; step();
    check(byte_ok === 1, "R8 byte_ok follows byte_evt", byte_ok, 1);

    // random phase
    arm(0); step();
    for (int i = 0; i < 20000; i++) begin
      xfer_active    = ($urandom % 50) != 0;
      first_bit_sent = ($urandom % 80) != 0;
      wait_resp      = ($urandom % 100) != 0;
      tick           = ($urandom % 3) == 0;
      resp_evt       = ($urandom % 900) == 0;
      byte_done      = ($urandom % 8) == 0;
      second_to      = ($urandom % 4) == 0;
      byte_evt       = ($urandom % 10) == 0;
      clr_err        = ($urandom % 200) == 0;
      if (i % 4000 < 1500) begin arm(1); resp_evt = 0; end
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule